// File: doc/BRIEF.md
# Euler Tour Tree Statistics Engine

This block computes four per-node statistics of a rooted tree: depth, preorder rank, postorder rank and subtree size. The tree arrives already linearized as its Euler tour. That is a stream of directed edges in which every tree link appears twice: once going down from parent to child and once coming back up. Each edge carries the parent index, the child index and a direction bit.

The engine keeps three running prefix sums over the tour, one for each edge-weighting scheme. It samples each sum at the edge that concerns a node and stores the results in per-node tables. The post-order sum seen at a node's downward edge is parked in a scratch table. When the node's upward edge arrives, the difference between the two sums gives its subtree size.

The final edge of a tour also fills in the root's entry. A done flag then tells the reader that the tables may be read through a combinational read port.

Edges are offered with `ev_valid` and taken on any rising clock edge where `ev_valid` and `ev_ready` are both high. Fields are ignored in cycles where `ev_valid` is low. The engine never applies back-pressure once out of reset: `ev_ready` is low only during reset and rises on the first clock after reset is released. A source may insert idle cycles between edges freely.

Top module: `etour_stats`

## Requirements
- R1: While reset is held and after its release, `tour_done` is 0, and every node reads level 0, preorder 0, postorder 0 and size 0 until written. `ev_ready` is 0 in reset and 1 from the first clock after release.
- R2: An edge is consumed only on a rising edge with `ev_valid` and `ev_ready` high. In cycles with `ev_valid` low, every field (including `ev_last`) has no effect on the tables or on `tour_done`.
- R3: A downward edge (`ev_up`=0) sets the child's level to the running depth sum after that edge. Downward edges add +1 and upward edges (`ev_up`=1) add -1, so a child of the root has level 1.
- R4: A downward edge sets the child's preorder rank to 1 plus the count of downward edges up to and including it. The root ranks 1.
- R5: An upward edge sets the child's postorder rank to the count of upward edges up to and including it.
- R6: An upward edge sets the child's subtree size (the node plus all nodes below it). The size is the upward-edge count at this edge minus the count held from that child's downward edge.
- R7: The edge flagged `ev_last` (an upward edge) also writes the root, taken as its parent field, in the same clock. The root gets level 0, preorder 1, and postorder and size both equal to n. Here n is the number of upward edges in the tour plus 1.
- R8: `tour_done` becomes 1 in the cycle after the last edge is accepted. It stays 1 until the next edge is accepted, and is 0 in the cycle after that edge.
- R9: Every tour starts its prefix sums from zero. Nodes not named in a tour keep the values written by earlier tours.
- R10: Depth is exact up to MAX_NODES-1: a 16-node chain gives its deepest node level 15 and its root postorder and size 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Edge offered |
| ev_ready | output | 1 | Engine can take an edge |
| ev_up | input | 1 | 1 = child to parent, 0 = parent to child |
| ev_last | input | 1 | Marks the final edge of the tour |
| ev_parent | input | IDX_W (4) | Parent end of the link |
| ev_child | input | IDX_W (4) | Child end of the link |
| tour_done | output | 1 | Tables hold a complete tour |
| rd_idx | input | IDX_W (4) | Node to read |
| rd_level | output | SUM_W (6) | Depth of node, signed |
| rd_pre | output | CNT_W (5) | Preorder rank |
| rd_post | output | CNT_W (5) | Postorder rank |
| rd_size | output | CNT_W (5) | Subtree size including the node |

## Verification
The final edge of a tour does two things in one clock. It completes its child's postorder rank and subtree size, and it writes all four fields of the root. These are writes to two different table entries through separate enable paths. The bench triggers this overlap at the end of every tour. It then reads both the last child (for example, node 1 of the six-node tree, with size 2 and postorder 5) and the root (size and postorder 6), so that a lost or swapped write shows up in either entry. A checker also requires that, while `tour_done` is high, the root address reads level 0 and preorder 1 with equal postorder and size.

// File: rtl/etour_pkg.sv
package etour_pkg;
  typedef enum logic [1:0] {
    M_DEPTH = 2'd0,
    M_PRE   = 2'd1,
    M_POST  = 2'd2
  } metric_e;

  localparam int NUM_METRICS = 3;

  // per-edge weight for each metric, selected by direction
  function automatic logic signed [1:0] edge_weight(metric_e k, logic up);
    case (k)
      M_DEPTH: return up ? -2'sd1 : 2'sd1;
      M_PRE:   return up ?  2'sd0 : 2'sd1;
      default: return up ?  2'sd1 : 2'sd0;
    endcase
  endfunction
endpackage

// File: rtl/etour_prefix.sv
module etour_prefix
  import etour_pkg::*;
#(
  parameter int      W    = 6,
  parameter metric_e KIND = M_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                up,
  input  logic                last,
  output logic signed [W-1:0] sum_now
);
  logic signed [1:0]   wt;
  logic signed [W-1:0] wt_ext;
  logic signed [W-1:0] acc_q;

  assign wt      = edge_weight(KIND, up);
  assign wt_ext  = {{(W-2){wt[1]}}, wt};
  // prefix including the current edge
  assign sum_now = acc_q + wt_ext;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= last ? '0 : sum_now;
  end
endmodule

// File: rtl/etour_node_table.sv
module etour_node_table #(
  parameter int N     = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int SUM_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dn_we,
  input  logic [IDX_W-1:0]        dn_idx,
  input  logic signed [SUM_W-1:0] dn_level,
  input  logic [CNT_W-1:0]        dn_pre,
  input  logic [CNT_W-1:0]        dn_mark,
  input  logic                    up_we,
  input  logic [IDX_W-1:0]        up_idx,
  input  logic [CNT_W-1:0]        up_post,
  input  logic                    root_we,
  input  logic [IDX_W-1:0]        root_idx,
  input  logic [CNT_W-1:0]        root_n,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [SUM_W-1:0] rd_level,
  output logic [CNT_W-1:0]        rd_pre,
  output logic [CNT_W-1:0]        rd_post,
  output logic [CNT_W-1:0]        rd_size
);
  logic signed [SUM_W-1:0] lvl_a  [N];
  logic [CNT_W-1:0]        pre_a  [N];
  logic [CNT_W-1:0]        post_a [N];
  logic [CNT_W-1:0]        size_a [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic signed [SUM_W-1:0] lvl_q;
    logic [CNT_W-1:0]        pre_q, post_q, size_q, mark_q;
    logic                    hit_root, hit_dn, hit_up;

    assign hit_root = root_we && (root_idx == IDX_W'(i));
    assign hit_dn   = dn_we   && (dn_idx   == IDX_W'(i));
    assign hit_up   = up_we   && (up_idx   == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl_q  <= '0;
        pre_q  <= '0;
        post_q <= '0;
        size_q <= '0;
        mark_q <= '0;
      end else if (hit_root) begin
        lvl_q  <= '0;
        pre_q  <= CNT_W'(1);
        post_q <= root_n;
        size_q <= root_n;
      end else begin
        if (hit_dn) begin
          lvl_q  <= dn_level;
          pre_q  <= dn_pre;
          mark_q <= dn_mark;
        end
        if (hit_up) begin
          post_q <= up_post;
          size_q <= up_post - mark_q;
        end
      end
    end

    assign lvl_a[i]  = lvl_q;
    assign pre_a[i]  = pre_q;
    assign post_a[i] = post_q;
    assign size_a[i] = size_q;
  end

  assign rd_level = lvl_a[rd_idx];
  assign rd_pre   = pre_a[rd_idx];
  assign rd_post  = post_a[rd_idx];
  assign rd_size  = size_a[rd_idx];
endmodule

// File: rtl/etour_stats.sv
module etour_stats
  import etour_pkg::*;
#(
  parameter int MAX_NODES = 16,
  parameter int IDX_W     = $clog2(MAX_NODES),
  parameter int CNT_W     = $clog2(MAX_NODES + 1),
  parameter int SUM_W     = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ev_valid,
  output logic                    ev_ready,
  input  logic                    ev_up,
  input  logic                    ev_last,
  input  logic [IDX_W-1:0]        ev_parent,
  input  logic [IDX_W-1:0]        ev_child,
  output logic                    tour_done,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic signed [SUM_W-1:0] rd_level,
  output logic [CNT_W-1:0]        rd_pre,
  output logic [CNT_W-1:0]        rd_post,
  output logic [CNT_W-1:0]        rd_size
);
  logic                    rdy_q, done_q, take;
  logic signed [SUM_W-1:0] sum_now [NUM_METRICS];
  logic [CNT_W-1:0]        pre_cnt, post_cnt;

  assign take = ev_valid && rdy_q;

  for (genvar g = 0; g < NUM_METRICS; g++) begin : g_pfx
    etour_prefix #(.W(SUM_W), .KIND(metric_e'(g))) u_pfx (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (take),
      .up      (ev_up),
      .last    (ev_last),
      .sum_now (sum_now[g])
    );
  end

  assign pre_cnt  = sum_now[M_PRE][CNT_W-1:0];
  assign post_cnt = sum_now[M_POST][CNT_W-1:0];

  etour_node_table #(.N(MAX_NODES), .IDX_W(IDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .dn_we    (take && !ev_up),
    .dn_idx   (ev_child),
    .dn_level (sum_now[M_DEPTH]),
    .dn_pre   (pre_cnt + CNT_W'(1)),
    .dn_mark  (post_cnt),
    .up_we    (take && ev_up),
    .up_idx   (ev_child),
    .up_post  (post_cnt),
    .root_we  (take && ev_last),
    .root_idx (ev_parent),
    .root_n   (post_cnt + CNT_W'(1)),
    .rd_idx   (rd_idx),
    .rd_level (rd_level),
    .rd_pre   (rd_pre),
    .rd_post  (rd_post),
    .rd_size  (rd_size)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (take) done_q <= ev_last;
    end
  end

  assign ev_ready  = rdy_q;
  assign tour_done = done_q;
endmodule

// File: rtl/etour_stats_chk.sv
module etour_stats_chk #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 5,
  parameter int SUM_W = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ev_valid,
  input logic                    ev_ready,
  input logic                    ev_last,
  input logic [IDX_W-1:0]        ev_parent,
  input logic                    tour_done,
  input logic [IDX_W-1:0]        rd_idx,
  input logic signed [SUM_W-1:0] rd_level,
  input logic [CNT_W-1:0]        rd_pre,
  input logic [CNT_W-1:0]        rd_post,
  input logic [CNT_W-1:0]        rd_size
);
  logic [IDX_W-1:0] root_seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) root_seen_q <= '0;
    else if (ev_valid && ev_ready && ev_last) root_seen_q <= ev_parent;
  end

  // R2: ready is restored one clock after reset and then held
  a_r2_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ready |=> ev_ready);

  // R8: done follows acceptance of the last edge
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_last) |=> tour_done);

  // R8: done drops when a further non-final edge is taken
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && !ev_last) |=> !tour_done);

  // R7: root entry after a complete tour
  a_r7_root_values: assert property (@(posedge clk) disable iff (!rst_n)
    (tour_done && rd_idx == root_seen_q) |->
      (rd_level == '0 && rd_pre == CNT_W'(1) && rd_post == rd_size));

  // R6: a subtree never exceeds the postorder rank of its top node
  a_r6_size_le_post: assert property (@(posedge clk) disable iff (!rst_n)
    tour_done |-> (rd_size <= rd_post));
endmodule

bind etour_stats etour_stats_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ev_valid  (ev_valid),
  .ev_ready  (ev_ready),
  .ev_last   (ev_last),
  .ev_parent (ev_parent),
  .tour_done (tour_done),
  .rd_idx    (rd_idx),
  .rd_level  (rd_level),
  .rd_pre    (rd_pre),
  .rd_post   (rd_post),
  .rd_size   (rd_size)
);

// File: tb/etour_stats_tb_top.sv
module etour_stats_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ev_valid = 1'b0, ev_up = 1'b0, ev_last = 1'b0;
  logic [3:0]        ev_parent = '0, ev_child = '0, rd_idx = '0;
  logic              ev_ready, tour_done;
  logic signed [5:0] rd_level;
  logic [4:0]        rd_pre, rd_post, rd_size;

  int n_checks = 0;
  int n_fail   = 0;

  logic [3:0] tp [64];
  logic [3:0] tc [64];
  logic       tu [64];
  int         tlen = 0;

  always #2 clk = ~clk;

  etour_stats dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_up(ev_up), .ev_last(ev_last), .ev_parent(ev_parent), .ev_child(ev_child),
    .tour_done(tour_done), .rd_idx(rd_idx), .rd_level(rd_level),
    .rd_pre(rd_pre), .rd_post(rd_post), .rd_size(rd_size)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_node(input string tag, input int idx, input int lv,
                          input int pr, input int po, input int sz);
    @(negedge clk);
    rd_idx = 4'(idx);
    #1;
    chk($sformatf("%s n%0d level", tag, idx), int'(rd_level), lv);
    chk($sformatf("%s n%0d pre", tag, idx), int'(rd_pre), pr);
    chk($sformatf("%s n%0d post", tag, idx), int'(rd_post), po);
    chk($sformatf("%s n%0d size", tag, idx), int'(rd_size), sz);
  endtask

  task automatic push(input int p, input int c, input bit up);
    tp[tlen] = 4'(p); tc[tlen] = 4'(c); tu[tlen] = up;
    tlen++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done in reset", int'(tour_done), 0);
    chk("R1 ready in reset", int'(ev_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(ev_ready), 1);
  endtask

  // gap > 0 inserts idle cycles with junk fields, including a false last flag
  task automatic run_tour(input int gap);
    for (int k = 0; k < tlen; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        ev_valid = 1'b0; ev_last = 1'b1; ev_up = 1'b1;
        ev_parent = 4'hE; ev_child = 4'hD;
        if (k == 1 && g == 0) begin
          #1;
          chk("R2 junk last ignored", int'(tour_done), 0);
        end
      end
      @(negedge clk);
      if (k == tlen - 1) chk("R8 done low before last", int'(tour_done), 0);
      ev_valid = 1'b1; ev_parent = tp[k]; ev_child = tc[k];
      ev_up = tu[k]; ev_last = (k == tlen - 1);
      @(posedge clk);
      while (!ev_ready) @(posedge clk);
    end
    @(negedge clk);
    ev_valid = 1'b0; ev_last = 1'b0;
    chk("R8 done after last", int'(tour_done), 1);
    tlen = 0;
  endtask

  task automatic load_tree_a();
    push(3, 7, 0); push(7, 0, 0); push(7, 0, 1); push(7, 5, 0); push(7, 5, 1);
    push(3, 7, 1); push(3, 1, 0); push(1, 9, 0); push(1, 9, 1); push(3, 1, 1);
  endtask

  task automatic t_reset();
    do_reset();
    for (int i = 0; i < 16; i++) chk_node("R1 cleared", i, 0, 0, 0, 0);
  endtask

  task automatic check_tree_a(input string tag);
    chk_node({tag, " R3 R4 R5 R6 leaf"}, 0, 2, 3, 1, 1);
    chk_node({tag, " R3 R4 R5 R6 leaf"}, 5, 2, 4, 2, 1);
    chk_node({tag, " R3 R4 R5 R6 inner"}, 7, 1, 2, 3, 3);
    chk_node({tag, " R3 R4 R5 R6 leaf"}, 9, 2, 6, 4, 1);
    chk_node({tag, " R6 last child"}, 1, 1, 5, 5, 2);
    chk_node({tag, " R7 root"}, 3, 0, 1, 6, 6);
    chk_node({tag, " R9 untouched"}, 12, 0, 0, 0, 0);
  endtask

  task automatic t_tree_a();
    load_tree_a();
    run_tour(0);
    check_tree_a("A");
  endtask

  task automatic t_tree_a_gaps();
    do_reset();
    load_tree_a();
    run_tour(2);
    check_tree_a("R2 gaps");
  endtask

  task automatic t_chain();
    for (int k = 15; k >= 1; k--) push(k, k - 1, 0);
    for (int k = 0; k <= 14; k++) push(k + 1, k, 1);
    run_tour(0);
    for (int k = 0; k < 15; k++) chk_node("R10 chain", k, 15 - k, 16 - k, k + 1, k + 1);
    chk_node("R10 R7 chain root", 15, 0, 1, 16, 16);
  endtask

  task automatic t_restart();
    push(8, 2, 0); push(8, 2, 1);
    @(negedge clk);
    ev_valid = 1'b1; ev_parent = tp[0]; ev_child = tc[0]; ev_up = tu[0]; ev_last = 1'b0;
    @(negedge clk);
    ev_valid = 1'b0;
    chk("R8 done clears on next tour", int'(tour_done), 0);
    tp[0] = tp[1]; tc[0] = tc[1]; tu[0] = tu[1]; tlen = 1;
    run_tour(1);
    chk_node("R9 R3 restart child", 2, 1, 2, 1, 1);
    chk_node("R9 R7 restart root", 8, 0, 1, 2, 2);
    chk_node("R9 stale kept", 5, 10, 11, 6, 6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_tree_a();
    t_tree_a_gaps();
    t_chain();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule